// File: doc/BRIEF.md
# MDIO Management Master with Command Register

This block is a management-interface master for Ethernet PHYs. A host controls it through one 32-bit command/status word. A host write places the PHY port address, the register or device address, the start code, the opcode and 16 bits of data into the word. When the go flag (bit 31) is set in that write, the block sends one IEEE 802.3 management frame on MDC/MDIO. While the frame is on the wire, bit 31 reads back as 1. It drops to 0 when the frame is finished.

The start code and the opcode travel from their register fields onto the wire unchanged. The same shift engine therefore produces both Clause 22 frames and the two frames of a Clause 45 access: an address frame, then a read or write frame that reuses the same port and device fields. For read opcodes the block releases MDIO at the turnaround. It then shifts the PHY's 16 reply bits into the low half of the word, where the host reads them once busy has cleared.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0, MDC is low and MDIO is not driven (`mdioOe` = 0).
- R2: A host write with bit 31 = 1 while idle starts a frame. Bit 31 then reads 1 for exactly PREAMBLE_LEN+32 MDC periods and returns to 0 when the last bit has been sent.
- R3: A host write while busy has no effect. It changes no field of the command word and starts no further frame.
- R4: MDC has a period of CLK_DIV system clocks with equal high and low halves. It stays low whenever no frame is in progress.
- R5: Every frame begins with PREAMBLE_LEN MDC periods (32 by default) with MDIO driven to 1.
- R6: After the preamble, the frame sends the following fields, each MSB first: bits 17:16 (start code; 01 selects Clause 22, 00 selects Clause 45), bits 19:18 (opcode), bits 24:20 (port address), bits 29:25 (register address for Clause 22, device address for Clause 45). MDIO changes only after a falling MDC edge.
- R7: Opcodes 0 (Clause 45 address) and 1 (write) keep MDIO driven for the whole frame. They send turnaround bits 1 then 0, followed by bits 15:0 of the command word. These frames leave the command word unchanged.
- R8: Opcodes 2 (Clause 22 read) and 3 (Clause 45 read) release MDIO from the first turnaround bit to the end of the frame. They sample 16 reply bits on rising MDC, MSB first, and place them in bits 15:0 when busy clears. Bits 30:16 keep their written values.
- R9: A Clause 45 access made of an address frame (opcode 0, register address in bits 15:0) followed by a write frame or a read frame (opcode 1 or 3) to the same port and device reaches the addressed register.
- R10: A host write with bit 31 = 0 while idle stores bits 30:0 without starting a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for the command word |
| hostWrData | input | 32 | Command word written by the host |
| hostRdData | output | 32 | Command word read back; bit 31 is busy |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (1 = master drives) |
| mdioIn | input | 1 | MDIO line as seen at the pad |

## Verification
The bench sweeps all 32 register addresses on one port and all 32 port addresses on one register, writing and then reading back through a behavioural PHY. It runs Clause 45 address/write/address/read sequences over several devices and register addresses. A design that turned the field order or bit order around would store data at the wrong PHY location and fail the read-back. A read that released MDIO one bit late would show up as the master driving during the turnaround, and a capture that was off by one bit would return shifted data. The bench also aims a host write at a frame in progress, and a write without the go flag at an idle block. Either write, if not ignored, would alter the fields that read back or add MDC edges.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  // command word field positions (the PHY decodes these in frame order)
  localparam int GO_BIT    = 31;
  localparam int REG_LSB   = 25;
  localparam int PORT_LSB  = 20;
  localparam int OP_LSB    = 18;
  localparam int START_LSB = 16;

  // frame body after preamble: start2 op2 port5 reg5 ta2 data16
  localparam int FRAME_BODY = 32;
  localparam int TA_OFFSET  = 14;
  localparam int DATA_OFFSET = 16;
  localparam logic [1:0] TA_DRIVEN = 2'b10;

  typedef enum logic { ST_IDLE, ST_RUN } mdioState_t;

  typedef struct packed {
    logic loadCmd;   // host write accepted into the command word
    logic sampleIn;  // capture one reply bit (rising MDC)
    logic finish;    // last falling MDC edge of the frame
  } mdioStrobes_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int PREAMBLE_LEN = 32,
  localparam int IDXW        = $clog2(PREAMBLE_LEN + FRAME_BODY)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWrEn,
  input  logic            hostGo,
  input  logic            isRead,
  output logic            busy,
  output logic            mdc,
  output logic [IDXW-1:0] bitIdx,
  output mdioStrobes_t    strobes
);

  localparam int HALF       = CLK_DIV / 2;
  localparam int HCW        = $clog2(HALF + 1);
  localparam int FRAME_BITS = PREAMBLE_LEN + FRAME_BODY;

  mdioState_t     state;
  logic [HCW-1:0] halfCnt;
  logic           tick;
  logic           lastBit;

  assign tick    = (halfCnt == HCW'(HALF - 1));
  assign lastBit = (bitIdx == IDXW'(FRAME_BITS - 1));
  assign busy    = (state == ST_RUN);

  always_comb begin
    strobes.loadCmd  = hostWrEn && (state == ST_IDLE);
    strobes.sampleIn = busy && tick && !mdc && isRead &&
                       (bitIdx >= IDXW'(PREAMBLE_LEN + DATA_OFFSET));
    strobes.finish   = busy && tick && mdc && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      mdc     <= 1'b0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          halfCnt <= '0;
          mdc     <= 1'b0;
          if (strobes.loadCmd && hostGo) begin
            state  <= ST_RUN;
            bitIdx <= '0;
          end
        end
        default: begin
          if (tick) begin
            halfCnt <= '0;
            mdc     <= ~mdc;
            if (mdc) begin
              if (lastBit) state <= ST_IDLE;
              else bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_cmd_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  localparam int IDXW        = $clog2(PREAMBLE_LEN + FRAME_BODY)
) (
  input  logic            clk,
  input  logic            rstN,
  input  mdioStrobes_t    strobes,
  input  logic            busy,
  input  logic [IDXW-1:0] bitIdx,
  input  logic [31:0]     hostWrData,
  output logic [30:0]     cmdView,
  output logic            isRead,
  output logic            mdioOut,
  output logic            mdioOe,
  input  logic            mdioIn
);

  logic [30:0]     cmdReg;
  logic [15:0]     capShift;
  logic            inFrame;
  logic [IDXW-1:0] diff;
  logic [4:0]      offset;
  logic [31:0]     frameWord;

  assign isRead  = cmdReg[OP_LSB + 1];
  assign cmdView = cmdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      capShift <= '0;
    end else begin
      if (strobes.loadCmd) cmdReg <= hostWrData[30:0];
      if (strobes.sampleIn) capShift <= {capShift[14:0], mdioIn};
      if (strobes.finish && isRead) cmdReg[15:0] <= capShift;
    end
  end

  always_comb begin
    inFrame   = (bitIdx >= IDXW'(PREAMBLE_LEN));
    diff      = bitIdx - IDXW'(PREAMBLE_LEN);
    offset    = diff[4:0];
    frameWord = {cmdReg[START_LSB +: 2], cmdReg[OP_LSB +: 2],
                 cmdReg[PORT_LSB +: 5], cmdReg[REG_LSB +: 5],
                 TA_DRIVEN, cmdReg[15:0]};
    mdioOut   = inFrame ? frameWord[5'd31 - offset] : 1'b1;
    mdioOe    = busy && !(isRead && inFrame && (offset >= 5'(TA_OFFSET)));
  end

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  localparam int IDXW = $clog2(PREAMBLE_LEN + FRAME_BODY);

  mdioStrobes_t    strobes;
  logic            busy;
  logic            isRead;
  logic [IDXW-1:0] bitIdx;
  logic [30:0]     cmdView;

  mdio_ctrl #(.CLK_DIV(CLK_DIV), .PREAMBLE_LEN(PREAMBLE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn),
    .hostGo(hostWrData[GO_BIT]), .isRead(isRead), .busy(busy),
    .mdc(mdc), .bitIdx(bitIdx), .strobes(strobes)
  );

  mdio_dpath #(.PREAMBLE_LEN(PREAMBLE_LEN)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .bitIdx(bitIdx), .hostWrData(hostWrData), .cmdView(cmdView),
    .isRead(isRead), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign hostRdData = {busy, cmdView};

endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk #(
  parameter int CLK_DIV      = 4,
  parameter int PREAMBLE_LEN = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [31:0] hostWrData,
  input logic [31:0] hostRdData,
  input logic        mdc,
  input logic        mdioOe,
  input logic        busy
);

  localparam int MAX_BUSY = (PREAMBLE_LEN + 32) * CLK_DIV;

  int busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= 0;
    else busyCnt <= busyCnt + 1;
  end

  // R4
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R4
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdc) |=> $stable(mdc));

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hostWrEn && hostWrData[31]) |=> busy);

  // R2
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= MAX_BUSY);

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn) |=> (hostRdData[30:16] == $past(hostRdData[30:16])));

  // R8
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

  // R10
  nogo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hostWrEn && !hostWrData[31]) |=> !busy);

endmodule

bind mdio_cmd_master mdio_cmd_chk #(.CLK_DIV(CLK_DIV), .PREAMBLE_LEN(PREAMBLE_LEN)) uChk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
  .hostRdData(hostRdData), .mdc(mdc), .mdioOe(mdioOe), .busy(busy)
);

// File: tb/sim_mdio_cmd_master.sv
`timescale 1ns/1ps
module sim_mdio_cmd_master;

  localparam int CLK_DIV = 4;
  localparam int PRE     = 32;
  localparam int NBITS   = PRE + 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  logic phyEn = 1'b0;
  logic phyVal = 1'b1;
  assign mdioIn = mdioOe ? mdioOut : (phyEn ? phyVal : 1'b1);

  always #2 clk = ~clk;

  mdio_cmd_master #(.CLK_DIV(CLK_DIV), .PREAMBLE_LEN(PRE)) u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural PHY
  logic        lineBits [NBITS];
  logic        oeBits   [NBITS];
  int          riseCnt = 0;
  logic [1:0]  rStart, rOp;
  logic [4:0]  rPort, rReg;
  logic [15:0] rdVal;
  logic [15:0] c22Mem [32][32];
  logic [15:0] c45Mem [32][16];
  logic [15:0] addrLatch [32];

  always @(posedge mdc) begin
    int idx;
    logic [15:0] wd;
    #1;
    idx = riseCnt;
    if (idx < NBITS) begin
      lineBits[idx] = mdioIn;
      oeBits[idx]   = mdioOe;
    end
    riseCnt = riseCnt + 1;
    if (idx == PRE + 13) begin
      rStart = {lineBits[PRE], lineBits[PRE+1]};
      rOp    = {lineBits[PRE+2], lineBits[PRE+3]};
      for (int j = 0; j < 5; j++) begin
        rPort[4-j] = lineBits[PRE+4+j];
        rReg[4-j]  = lineBits[PRE+9+j];
      end
    end
    if (idx == PRE + 14 && rOp[1]) begin
      rdVal  = (rStart == 2'b01) ? c22Mem[rPort][rReg]
                                 : c45Mem[rReg][addrLatch[rPort][3:0]];
      phyEn  = 1'b1;
      phyVal = 1'b0;
    end
    if (idx >= PRE + 15 && idx <= PRE + 30 && rOp[1])
      phyVal = rdVal[PRE + 30 - idx];
    if (idx == NBITS - 1) begin
      phyEn = 1'b0;
      if (!rOp[1]) begin
        for (int j = 0; j < 16; j++) wd[15-j] = lineBits[PRE+16+j];
        if (rOp == 2'd0) addrLatch[rPort] = wd;
        else if (rStart == 2'b01) c22Mem[rPort][rReg] = wd;
        else c45Mem[rReg][addrLatch[rPort][3:0]] = wd;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] port, input logic [4:0] rg,
                                        input logic [15:0] data);
    return {1'b1, 1'b0, rg, port, op, st, data};
  endfunction

  task automatic launch(input logic [31:0] cmd);
    riseCnt = 0;
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrData = cmd;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic waitDone(output logic [31:0] rd);
    @(negedge clk);
    while (hostRdData[31]) @(negedge clk);
    rd = hostRdData;
  endtask

  task automatic checkFrame(input logic [31:0] cmd, input logic [31:0] rd,
                            input logic [15:0] expRead);
    logic [13:0] hdr, expHdr;
    logic [15:0] dat;
    bit preOk, oeHead, oeTail, drvTail;
    preOk = 1'b1; oeHead = 1'b1; oeTail = 1'b1; drvTail = 1'b1;
    for (int i = 0; i < PRE; i++) if (!lineBits[i] || !oeBits[i]) preOk = 1'b0;
    for (int i = 0; i < 14; i++) begin
      hdr[13-i] = lineBits[PRE+i];
      if (!oeBits[PRE+i]) oeHead = 1'b0;
    end
    for (int i = 14; i < 32; i++) begin
      if (oeBits[PRE+i]) oeTail = 1'b0;
      if (!oeBits[PRE+i]) drvTail = 1'b0;
    end
    for (int i = 0; i < 16; i++) dat[15-i] = lineBits[PRE+16+i];
    expHdr = {cmd[17:16], cmd[19:18], cmd[24:20], cmd[29:25]};
    check(riseCnt == NBITS, "R2", "MDC periods per frame", riseCnt, NBITS);
    check(rd[31] == 1'b0, "R2", "busy after frame", rd[31], 0);
    check(preOk, "R5", "preamble ones driven", preOk, 1);
    check(hdr == expHdr && oeHead, "R6", "header bits", hdr, expHdr);
    if (!cmd[19]) begin
      check(drvTail, "R7", "write frame drive", drvTail, 1);
      check({lineBits[PRE+14], lineBits[PRE+15]} == 2'b10, "R7", "write turnaround",
            {lineBits[PRE+14], lineBits[PRE+15]}, 2);
      check(dat == cmd[15:0], "R7", "write data bits", dat, cmd[15:0]);
      check(rd[30:0] == cmd[30:0], "R7", "word unchanged", rd[30:0], cmd[30:0]);
    end else begin
      check(oeTail, "R8", "read release", oeTail, 1);
      check(rd[15:0] == expRead, "R8", "read data", rd[15:0], expRead);
      check(rd[30:16] == cmd[30:16], "R8", "read upper fields", rd[30:16], cmd[30:16]);
    end
  endtask

  function automatic logic [15:0] c22Pat(input int port, input int rg);
    return 16'hA5C3 ^ 16'(rg * 16'h0111) ^ 16'(port * 16'h1309);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, cmd, cmd2;
    realtime t0, t1, t2;
    int riseSnap;
    bit idleLow;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hostRdData == 32'h0, "R1", "reset word", hostRdData, 0);
    check(!mdc && !mdioOe, "R1", "reset mdc/oe", {mdc, mdioOe}, 0);

    // R10 write without go
    cmd = mkCmd(2'b01, 2'd1, 5'd9, 5'd9, 16'h1234) & 32'h7FFF_FFFF;
    riseCnt = 0;
    @(negedge clk); hostWrEn = 1'b1; hostWrData = cmd;
    @(negedge clk); hostWrEn = 1'b0;
    repeat (300) @(negedge clk);
    check(riseCnt == 0 && !hostRdData[31], "R10", "no frame without go", riseCnt, 0);
    check(hostRdData == cmd, "R10", "fields stored", hostRdData, cmd);

    // R4 MDC timing on first frame
    cmd = mkCmd(2'b01, 2'd1, 5'd3, 5'd0, c22Pat(3, 0));
    launch(cmd);
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    check(t2 - t0 == CLK_DIV * 4.0, "R4", "MDC period ns", longint'(t2 - t0), CLK_DIV * 4);
    check(t1 - t0 == CLK_DIV * 2.0, "R4", "MDC high ns", longint'(t1 - t0), CLK_DIV * 2);
    waitDone(rd);
    checkFrame(cmd, rd, 16'h0);
    idleLow = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mdc) idleLow = 1'b0;
    end
    check(idleLow, "R4", "MDC low when idle", idleLow, 1);

    // Clause 22 register sweep on port 3
    for (int r = 1; r < 32; r++) begin
      cmd = mkCmd(2'b01, 2'd1, 5'd3, 5'(r), c22Pat(3, r));
      launch(cmd); waitDone(rd); checkFrame(cmd, rd, 16'h0);
    end
    for (int r = 0; r < 32; r++) begin
      cmd = mkCmd(2'b01, 2'd2, 5'd3, 5'(r), 16'h0);
      launch(cmd); waitDone(rd); checkFrame(cmd, rd, c22Pat(3, r));
    end

    // Clause 22 port sweep on register 31
    for (int p = 0; p < 32; p++) begin
      cmd = mkCmd(2'b01, 2'd1, 5'(p), 5'd31, c22Pat(p, 31));
      launch(cmd); waitDone(rd); checkFrame(cmd, rd, 16'h0);
    end
    for (int p = 0; p < 32; p++) begin
      cmd = mkCmd(2'b01, 2'd2, 5'(p), 5'd31, 16'hFFFF);
      launch(cmd); waitDone(rd); checkFrame(cmd, rd, c22Pat(p, 31));
    end

    // R9 Clause 45 address then write, address then read
    for (int d = 0; d < 3; d++) begin
      for (int k = 0; k < 4; k++) begin
        logic [4:0]  dev;
        logic [15:0] addr, val;
        dev  = (d == 0) ? 5'd1 : (d == 1) ? 5'd7 : 5'd31;
        addr = 16'h8000 | 16'(dev) << 4 | 16'(k);
        val  = 16'h5A00 ^ 16'(dev * 16'h0203) ^ 16'(k * 16'h1111);
        cmd = mkCmd(2'b00, 2'd0, 5'd6, dev, addr);
        launch(cmd); waitDone(rd); checkFrame(cmd, rd, 16'h0);
        check(rd[15:0] == addr, "R9", "address frame keeps addr", rd[15:0], addr);
        cmd = mkCmd(2'b00, 2'd1, 5'd6, dev, val);
        launch(cmd); waitDone(rd); checkFrame(cmd, rd, 16'h0);
      end
      for (int k = 0; k < 4; k++) begin
        logic [4:0]  dev;
        logic [15:0] addr, val;
        dev  = (d == 0) ? 5'd1 : (d == 1) ? 5'd7 : 5'd31;
        addr = 16'h8000 | 16'(dev) << 4 | 16'(k);
        val  = 16'h5A00 ^ 16'(dev * 16'h0203) ^ 16'(k * 16'h1111);
        cmd = mkCmd(2'b00, 2'd0, 5'd6, dev, addr);
        launch(cmd); waitDone(rd); checkFrame(cmd, rd, 16'h0);
        cmd = mkCmd(2'b00, 2'd3, 5'd6, dev, 16'h0);
        launch(cmd); waitDone(rd); checkFrame(cmd, rd, val);
        check(rd[15:0] == val, "R9", "clause 45 read-back", rd[15:0], val);
      end
    end

    // R3 write during busy is ignored
    cmd  = mkCmd(2'b01, 2'd1, 5'd2, 5'd4, 16'hBEEF);
    cmd2 = mkCmd(2'b01, 2'd1, 5'd2, 5'd4, 16'h0F0F) ^ 32'h3FF0_0000;
    launch(cmd);
    repeat (20) @(negedge clk);
    hostWrEn = 1'b1; hostWrData = cmd2;
    @(negedge clk); hostWrEn = 1'b0;
    waitDone(rd);
    check(rd[30:0] == cmd[30:0], "R3", "word after busy write", rd[30:0], cmd[30:0]);
    riseSnap = riseCnt;
    repeat (300) @(negedge clk);
    check(riseCnt == NBITS && riseSnap == NBITS && !hostRdData[31], "R3",
          "no extra frame", riseCnt, NBITS);
    cmd = mkCmd(2'b01, 2'd2, 5'd2, 5'd4, 16'h0);
    launch(cmd); waitDone(rd); checkFrame(cmd, rd, 16'hBEEF);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule